// File: doc/BRIEF.md
# Three-Level Inverter Neutral-Point Predictor with Gate Encoder

This block sits in the control loop of a three-phase, three-level T-type inverter. Once per sampling period the controller presents the switching state it has chosen (one signed ternary code per leg), the three filter-current samples and the present neutral-point voltage, and pulses a strobe. On the next clock the block presents two results. The first is the neutral-point voltage predicted for the following sample. The second is the twelve gate enables that realise the chosen state, four per leg. The controller uses the prediction to decide which redundant small vector will pull the capacitor midpoint back toward balance.

Only a leg that is clamped to the midpoint draws its filter current through the neutral point. The prediction is therefore the present voltage minus a scaled, masked sum of the leg currents. The scale factor stands for the sampling time divided by one DC-link capacitance, with both capacitors taken as equal and the total link voltage as constant. It is loaded as an unsigned fixed-point constant through a configuration port. The product is rounded and clamped to the voltage width. A disable input forces every gate enable low at once.

Top module: `tt_np_predictor`

## Requirements
- R1: Each leg takes a 2-bit two's-complement code: 01 means +1 (upper rail), 00 means 0 (midpoint) and 11 means -1 (lower rail). Leg x drives gate[4x+3:4x], with bit 0 as switch 1 through bit 3 as switch 4. The patterns are 0011 for +1, 0110 for 0 and 1100 for -1.
- R2: The unused code 10 is treated exactly as the midpoint state. It drives pattern 0110, and its current is counted in the prediction.
- R3: The prediction is v_np - round(gain * S / 2^K_FRAC), where S is the sum of the currents of the midpoint legs. The rounding adds 2^(K_FRAC-1) and then floors, so an exact half moves toward +infinity.
- R4: A leg coded +1 or -1 contributes nothing to the prediction, whatever its current.
- R5: A prediction outside the signed VNP_W range is clamped to the largest or the smallest representable value.
- R6: A strobe sampled at a clock edge updates v_np_next and the gate register at that edge. out_valid is high for exactly the one cycle that follows each strobed edge.
- R7: Between strobes, v_np_next holds its value and out_valid stays low.
- R8: cfg_load captures cfg_gain at the clock edge. A strobe at the same edge still uses the previously loaded gain, and later strobes use the new one.
- R9: While enable is low, all gate outputs are 0 in the same cycle. Strobes while disabled still update the prediction, but they do not arm a pattern. After enable returns, the gates stay 0 until the next strobe.
- R10: After reset the gates, v_np_next, out_valid and the gain are all 0. A strobe before any load therefore returns v_np unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Gate enable; low forces all gates off |
| sample_stb | input | 1 | Single-cycle sample strobe |
| leg_code | input | 2*NUM_LEGS | Per-leg ternary state code, leg 0 in the low bits |
| i_filt | input | NUM_LEGS*CUR_W | Signed filter currents, leg 0 in the low bits |
| v_np | input | VNP_W | Present signed neutral-point voltage |
| cfg_gain | input | K_W | Unsigned scale constant with K_FRAC fractional bits |
| cfg_load | input | 1 | Loads cfg_gain into the gain register |
| v_np_next | output | VNP_W | Predicted signed neutral-point voltage |
| gate | output | 4*NUM_LEGS | Switch enables, four per leg |
| out_valid | output | 1 | One-cycle pulse after each strobe |

## Verification
The bench targets the following corner cases:
- The unused leg code. A design that decoded it as a rail state would drive a wrong switch pair and drop that leg's current.
- Rail legs carrying large currents. A design that failed to mask them would drift the prediction.
- Exact half-LSB products of both signs. A design that truncated or rounded toward zero would be one count off on one side.
- Sums that overflow the voltage range in either direction. A design that did not clamp would wrap to the opposite sign.
- A gain load at the same edge as a strobe, and a re-enable without a new strobe. A design that got these wrong would apply the new gain early or replay a stale gate pattern.

// File: rtl/tt_np_pkg.sv
package tt_np_pkg;

   typedef enum logic [1:0] {
      LEG_MID  = 2'b00,
      LEG_HIGH = 2'b01,
      LEG_BAD  = 2'b10,
      LEG_LOW  = 2'b11
   } leg_code_e;

   // switch pattern, bit 0 = switch 1 ... bit 3 = switch 4
   function automatic logic [3:0] leg_gates(input leg_code_e code);
      logic [3:0] pat;
      case (code)
         LEG_HIGH: pat = 4'b0011;
         LEG_LOW:  pat = 4'b1100;
         default:  pat = 4'b0110;
      endcase
      return pat;
   endfunction

   // leg is tied to the midpoint (the unused code falls back to midpoint)
   function automatic logic leg_on_mid(input leg_code_e code);
      return (code != LEG_HIGH) && (code != LEG_LOW);
   endfunction

endpackage

// File: rtl/tt_np_leg.sv
module tt_np_leg
   import tt_np_pkg::*;
#(
   parameter int CUR_W = 16
) (
   input  logic [1:0]              code,
   input  logic signed [CUR_W-1:0] i_in,
   output logic [3:0]              pattern,
   output logic signed [CUR_W-1:0] i_mid
);
   leg_code_e code_e;

   assign code_e  = leg_code_e'(code);
   assign pattern = leg_gates(code_e);
   assign i_mid   = leg_on_mid(code_e) ? i_in : '0;

endmodule

// File: rtl/tt_np_sum.sv
module tt_np_sum #(
   parameter int NUM_LEGS = 3,
   parameter int CUR_W    = 16,
   parameter int SUM_W    = 18
) (
   input  logic [NUM_LEGS*CUR_W-1:0] i_flat,
   output logic signed [SUM_W-1:0]   sum
);
   always_comb begin
      sum = '0;
      for (int k = 0; k < NUM_LEGS; k++) begin
         sum = sum + SUM_W'($signed(i_flat[k*CUR_W +: CUR_W]));
      end
   end

endmodule

// File: rtl/tt_np_scale.sv
module tt_np_scale #(
   parameter int SUM_W  = 18,
   parameter int K_W    = 16,
   parameter int K_FRAC = 12,
   parameter int VNP_W  = 16
) (
   input  logic signed [SUM_W-1:0] sum,
   input  logic [K_W-1:0]          gain,
   input  logic signed [VNP_W-1:0] v_now,
   output logic signed [VNP_W-1:0] v_next
);
   localparam int PROD_W = SUM_W + K_W + 1;
   localparam int WIDE_W = PROD_W + 1;
   localparam int DIFF_W = WIDE_W + 1;

   logic signed [PROD_W-1:0] sum_x;
   logic signed [PROD_W-1:0] gain_x;
   logic signed [PROD_W-1:0] prod;
   logic signed [WIDE_W-1:0] prod_w;
   logic signed [WIDE_W-1:0] rnd;
   logic signed [WIDE_W-1:0] delta;
   logic signed [DIFF_W-1:0] diff;
   logic                     ovf_hi;
   logic                     ovf_lo;

   assign sum_x  = {{(PROD_W-SUM_W){sum[SUM_W-1]}}, sum};
   assign gain_x = {{(PROD_W-K_W){1'b0}}, gain};
   assign prod   = sum_x * gain_x;
   assign prod_w = {prod[PROD_W-1], prod};

   generate
      if (K_FRAC > 0) begin : g_round
         localparam logic signed [WIDE_W-1:0] HALF = WIDE_W'(1) <<< (K_FRAC - 1);
         assign rnd   = prod_w + HALF;
         assign delta = rnd >>> K_FRAC;
      end else begin : g_integer
         assign rnd   = prod_w;
         assign delta = rnd;
      end
   endgenerate

   assign diff = {{(DIFF_W-VNP_W){v_now[VNP_W-1]}}, v_now}
               - {delta[WIDE_W-1], delta};

   assign ovf_hi = !diff[DIFF_W-1] &&  (|diff[DIFF_W-2:VNP_W-1]);
   assign ovf_lo =  diff[DIFF_W-1] && !(&diff[DIFF_W-2:VNP_W-1]);

   always_comb begin
      if (ovf_hi)      v_next = {1'b0, {(VNP_W-1){1'b1}}};
      else if (ovf_lo) v_next = {1'b1, {(VNP_W-1){1'b0}}};
      else             v_next = diff[VNP_W-1:0];
   end

endmodule

// File: rtl/tt_np_predictor.sv
module tt_np_predictor #(
   parameter int NUM_LEGS = 3,
   parameter int CUR_W    = 16,
   parameter int VNP_W    = 16,
   parameter int K_W      = 16,
   parameter int K_FRAC   = 12
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      enable,
   input  logic                      sample_stb,
   input  logic [2*NUM_LEGS-1:0]     leg_code,
   input  logic [NUM_LEGS*CUR_W-1:0] i_filt,
   input  logic [VNP_W-1:0]          v_np,
   input  logic [K_W-1:0]            cfg_gain,
   input  logic                      cfg_load,
   output logic [VNP_W-1:0]          v_np_next,
   output logic [4*NUM_LEGS-1:0]     gate,
   output logic                      out_valid
);
   localparam int GATE_W = 4 * NUM_LEGS;
   localparam int SUM_W  = CUR_W + ((NUM_LEGS > 1) ? $clog2(NUM_LEGS) : 0);

   generate
      if (NUM_LEGS < 1) begin : g_bad_legs
         $error("NUM_LEGS must be at least 1");
      end
      if (CUR_W < 2) begin : g_bad_cur
         $error("CUR_W must be at least 2");
      end
      if (VNP_W < 2) begin : g_bad_vnp
         $error("VNP_W must be at least 2");
      end
      if (K_W < 1 || K_FRAC < 0 || K_FRAC > K_W) begin : g_bad_gain
         $error("gain format out of range");
      end
      if (VNP_W > SUM_W + K_W + 2) begin : g_bad_span
         $error("VNP_W too wide for the product path");
      end
   endgenerate

   logic [GATE_W-1:0]         gate_new;
   logic [NUM_LEGS*CUR_W-1:0] i_mid_flat;
   logic signed [SUM_W-1:0]   mid_sum;
   logic signed [VNP_W-1:0]   v_pred;

   logic [K_W-1:0]            gain_q;
   logic [VNP_W-1:0]          v_q;
   logic [GATE_W-1:0]         gate_q;
   logic                      valid_q;

   generate
      for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
         logic signed [CUR_W-1:0] i_leg_mid;
         tt_np_leg #(.CUR_W(CUR_W)) u_leg (
            .code    (leg_code[2*g +: 2]),
            .i_in    ($signed(i_filt[g*CUR_W +: CUR_W])),
            .pattern (gate_new[4*g +: 4]),
            .i_mid   (i_leg_mid)
         );
         assign i_mid_flat[g*CUR_W +: CUR_W] = i_leg_mid;
      end
   endgenerate

   tt_np_sum #(
      .NUM_LEGS (NUM_LEGS),
      .CUR_W    (CUR_W),
      .SUM_W    (SUM_W)
   ) u_sum (
      .i_flat (i_mid_flat),
      .sum    (mid_sum)
   );

   tt_np_scale #(
      .SUM_W  (SUM_W),
      .K_W    (K_W),
      .K_FRAC (K_FRAC),
      .VNP_W  (VNP_W)
   ) u_scale (
      .sum    (mid_sum),
      .gain   (gain_q),
      .v_now  ($signed(v_np)),
      .v_next (v_pred)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gain_q  <= '0;
         v_q     <= '0;
         gate_q  <= '0;
         valid_q <= 1'b0;
      end else begin
         if (cfg_load) gain_q <= cfg_gain;
         valid_q <= sample_stb;
         if (sample_stb) v_q <= v_pred;
         if (!enable)         gate_q <= '0;
         else if (sample_stb) gate_q <= gate_new;
      end
   end

   assign v_np_next = v_q;
   assign gate      = enable ? gate_q : '0;
   assign out_valid = valid_q;

endmodule

// File: rtl/tt_np_predictor_chk.sv
module tt_np_predictor_chk #(
   parameter int NUM_LEGS = 3,
   parameter int VNP_W    = 16
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  enable,
   input logic                  sample_stb,
   input logic [2*NUM_LEGS-1:0] leg_code,
   input logic [VNP_W-1:0]      v_np_next,
   input logic [4*NUM_LEGS-1:0] gate,
   input logic                  out_valid
);
   assert_gates_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> (gate == '0));

   assert_valid_after_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |=> out_valid);

   assert_no_valid_between_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_stb |=> !out_valid);

   assert_hold_prediction_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_stb |=> $stable(v_np_next));

   generate
      for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg_chk
         assert_legal_pattern_R1: assert property (@(posedge clk) disable iff (!rst_n)
            gate[4*g +: 4] inside {4'b0000, 4'b0011, 4'b0110, 4'b1100});

         assert_high_pattern_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (sample_stb && enable && leg_code[2*g +: 2] == 2'b01) |=>
               (!enable || gate[4*g +: 4] == 4'b0011));

         assert_low_pattern_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (sample_stb && enable && leg_code[2*g +: 2] == 2'b11) |=>
               (!enable || gate[4*g +: 4] == 4'b1100));

         assert_bad_code_mid_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (sample_stb && enable && leg_code[2*g +: 2] == 2'b10) |=>
               (!enable || gate[4*g +: 4] == 4'b0110));
      end
   endgenerate

endmodule

bind tt_np_predictor tt_np_predictor_chk #(
   .NUM_LEGS (NUM_LEGS),
   .VNP_W    (VNP_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .enable     (enable),
   .sample_stb (sample_stb),
   .leg_code   (leg_code),
   .v_np_next  (v_np_next),
   .gate       (gate),
   .out_valid  (out_valid)
);

// File: tb/tt_np_predictor_bench.sv
`timescale 1ns/1ps
module tt_np_predictor_bench;

   localparam int NL = 3;
   localparam int CW = 16;
   localparam int VW = 16;
   localparam int KW = 16;
   localparam int KF = 12;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            enable = 1'b1;
   logic            sample_stb = 1'b0;
   logic [2*NL-1:0] leg_code = '0;
   logic [NL*CW-1:0] i_filt = '0;
   logic [VW-1:0]   v_np = '0;
   logic [KW-1:0]   cfg_gain = '0;
   logic            cfg_load = 1'b0;
   logic [VW-1:0]   v_np_next;
   logic [4*NL-1:0] gate;
   logic            out_valid;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;
   longint gain_now = 0;

   always #5 clk = ~clk;

   tt_np_predictor #(
      .NUM_LEGS (NL), .CUR_W (CW), .VNP_W (VW), .K_W (KW), .K_FRAC (KF)
   ) u_tt_np_predictor (
      .clk (clk), .rst_n (rst_n), .enable (enable), .sample_stb (sample_stb),
      .leg_code (leg_code), .i_filt (i_filt), .v_np (v_np),
      .cfg_gain (cfg_gain), .cfg_load (cfg_load),
      .v_np_next (v_np_next), .gate (gate), .out_valid (out_valid)
   );

   task automatic check(input string req, input string what, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // expected values from the requirement text
   function automatic logic [3:0] exp_pat(input logic [1:0] c);
      if (c == 2'b01)      return 4'b0011;
      else if (c == 2'b11) return 4'b1100;
      else                 return 4'b0110;
   endfunction

   function automatic longint exp_next(input logic [1:0] c0, c1, c2,
                                       input int i0, i1, i2, input int v, input longint g);
      longint s = 0;
      longint d;
      longint r;
      if (!(c0 == 2'b01 || c0 == 2'b11)) s += i0;
      if (!(c1 == 2'b01 || c1 == 2'b11)) s += i1;
      if (!(c2 == 2'b01 || c2 == 2'b11)) s += i2;
      d = (s * g + (64'sd1 <<< (KF - 1))) >>> KF;
      r = v - d;
      if (r > 32767)  r = 32767;
      if (r < -32768) r = -32768;
      return r;
   endfunction

   task automatic load_gain(input longint g);
      cfg_gain = KW'(g);
      cfg_load = 1'b1;
      @(negedge clk);
      cfg_load = 1'b0;
      gain_now = g;
   endtask

   // drives one strobe; returns at the negedge after the capturing edge
   task automatic strobe(input logic [1:0] c0, c1, c2, input int i0, i1, i2, input int v);
      leg_code   = {c2, c1, c0};
      i_filt     = {CW'(i2), CW'(i1), CW'(i0)};
      v_np       = VW'(v);
      sample_stb = 1'b1;
      @(negedge clk);
      sample_stb = 1'b0;
   endtask

   task automatic run_and_check(input string req, input logic [1:0] c0, c1, c2,
                                input int i0, i1, i2, input int v);
      longint ev;
      ev = exp_next(c0, c1, c2, i0, i1, i2, v, gain_now);
      strobe(c0, c1, c2, i0, i1, i2, v);
      check(req, "v_np_next", longint'($signed(v_np_next)), ev);
      check(req, "gate", longint'(gate), longint'({exp_pat(c2), exp_pat(c1), exp_pat(c0)}));
      check("R6", "out_valid after strobe", longint'(out_valid), 1);
   endtask

   task automatic t_reset;
      @(negedge clk);
      check("R10", "gate in reset", longint'(gate), 0);
      check("R10", "v_np_next in reset", longint'(v_np_next), 0);
      check("R10", "out_valid in reset", longint'(out_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      gain_now = 0;
      strobe(2'b00, 2'b00, 2'b00, 100, 200, 300, 500);
      check("R10", "zero gain keeps v_np", longint'($signed(v_np_next)), 500);
   endtask

   task automatic t_encoding;
      load_gain(4096);
      run_and_check("R1", 2'b01, 2'b01, 2'b01, 500, -700, 900, 100);
      run_and_check("R1", 2'b00, 2'b00, 2'b00, 500, -700, 900, 100);
      run_and_check("R1", 2'b11, 2'b11, 2'b11, 500, -700, 900, 100);
      run_and_check("R1", 2'b01, 2'b00, 2'b11, 500, -700, 900, 100);
   endtask

   task automatic t_bad_code;
      run_and_check("R2", 2'b10, 2'b01, 2'b11, 1000, 2000, 3000, 0);
      check("R2", "bad code leg 0 pattern", longint'(gate[3:0]), 6);
   endtask

   task automatic t_masking;
      run_and_check("R4", 2'b01, 2'b11, 2'b01, 32767, -32768, 20000, -1234);
      check("R4", "rail legs leave v unchanged", longint'($signed(v_np_next)), -1234);
      load_gain(1234);
      run_and_check("R3", 2'b00, 2'b00, 2'b00, -1500, 2500, 777, -2000);
      run_and_check("R3", 2'b00, 2'b11, 2'b10, -9000, 4000, -3000, 7000);
   endtask

   task automatic t_rounding;
      load_gain(2048);
      strobe(2'b00, 2'b01, 2'b01, 3, 0, 0, 10);
      check("R3", "+1.5 rounds to 2", longint'($signed(v_np_next)), 8);
      strobe(2'b00, 2'b01, 2'b01, -3, 0, 0, 10);
      check("R3", "-1.5 rounds to -1", longint'($signed(v_np_next)), 11);
   endtask

   task automatic t_saturation;
      load_gain(4096);
      run_and_check("R5", 2'b00, 2'b00, 2'b00, -30000, -30000, -30000, 32000);
      check("R5", "clamp high", longint'($signed(v_np_next)), 32767);
      run_and_check("R5", 2'b00, 2'b00, 2'b10, 30000, 30000, 30000, -32000);
      check("R5", "clamp low", longint'($signed(v_np_next)), -32768);
   endtask

   task automatic t_hold;
      longint held;
      run_and_check("R6", 2'b00, 2'b01, 2'b11, 40, 50, 60, 77);
      held = longint'($signed(v_np_next));
      v_np   = 16'sd999;
      i_filt = '1;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check("R7", "out_valid low between strobes", longint'(out_valid), 0);
         check("R7", "v_np_next held", longint'($signed(v_np_next)), held);
      end
   endtask

   task automatic t_gain_race;
      load_gain(4096);
      cfg_gain = 16'd8192;
      cfg_load = 1'b1;
      strobe(2'b00, 2'b00, 2'b00, 100, 100, 100, 0);
      cfg_load = 1'b0;
      check("R8", "same-edge strobe uses old gain", longint'($signed(v_np_next)), -300);
      gain_now = 8192;
      strobe(2'b00, 2'b00, 2'b00, 100, 100, 100, 0);
      check("R8", "later strobe uses new gain", longint'($signed(v_np_next)), -600);
   endtask

   task automatic t_enable;
      load_gain(4096);
      run_and_check("R9", 2'b01, 2'b00, 2'b11, 10, 20, 30, 0);
      enable = 1'b0;
      #1;
      check("R9", "gates off at once", longint'(gate), 0);
      strobe(2'b00, 2'b00, 2'b00, 5, 5, 5, 100);
      check("R9", "prediction while disabled", longint'($signed(v_np_next)), 85);
      check("R9", "gates off while disabled", longint'(gate), 0);
      enable = 1'b1;
      @(negedge clk);
      check("R9", "no stale pattern after re-enable", longint'(gate), 0);
      run_and_check("R9", 2'b11, 2'b01, 2'b00, 1, 2, 3, 4);
   endtask

   initial begin : main
      t_reset();
      t_encoding();
      t_bad_code();
      t_masking();
      t_rounding();
      t_saturation();
      t_hold();
      t_gain_race();
      t_enable();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL R6 watchdog expired: actual 0 expected 1");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule